// File: doc/BRIEF.md
# Multiplexed LCD Scan Waveform Sequencer

This block produces the drive-level schedule for a multiplexed liquid-crystal panel with up to five common rows and sixty segment columns. An enable pulse from a slow oscillator advances an internal time base in the system clock domain. A two-bit duty select chooses how many common rows take part in the scan: three, four or five. Each row owns one time slot of sixteen oscillator ticks. Every slot is split into two half-phases of eight ticks, and the second half-phase inverts the polarity of the first, so the average voltage across every pixel is zero.

For each slot and half-phase, the block emits a two-bit level code per common output and per segment output. An external analog switch bank maps these codes to the bias rails. Segment codes come from the row word that the slot currently addresses. A blank input turns every pixel off and leaves the common scan running.

Top module: `lcdmux_drive_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the scan sits at slot 0, first half-phase. Common 0 shows H and every other common shows M2.
- R2: The duty select decodes as follows. `duty_sel`=2'b00 scans 3 rows. 2'b01 scans 4 rows. Any value with `duty_sel[1]`=1 scans 5 rows.
- R3: The time base advances only in cycles where `osc_tick` is 1. Each half-phase lasts exactly 8 ticks, so each slot lasts 16 ticks. Cycles without a tick leave every output unchanged.
- R4: Slots are visited in ascending order 0, 1, ... up to the last active row, then wrap to slot 0. Commons with an index at or above the active row count are never selected.
- R5: Level codes are H=2'b11, M1=2'b10, M2=2'b01 and L=2'b00. Common output c occupies bits [2c+1:2c]. The selected common drives H in the first half-phase and L in the second.
- R6: Every common that is not selected, including commons left unused by the current duty, drives M2 in the first half-phase and M1 in the second.
- R7: Segment s occupies bits [2s+1:2s] of `seg_lvl`. Its data bit for row r is `row_bits[r*60+s]`. When that bit is 1 for the current slot's row, the segment drives L in the first half-phase and H in the second.
- R8: When the segment's bit for the current row is 0, the segment drives M1 in the first half-phase and M2 in the second.
- R9: While `blank_en` is 1, every segment follows the off pattern of R8 whatever its data. The commons keep scanning unaffected.
- R10: A change in the decoded row count restarts the scan at slot 0, first half-phase, tick 0, one clock after the change appears. A change in `duty_sel[0]` while `duty_sel[1]`=1 leaves the row count unchanged and does not restart the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable pulse from the scan oscillator |
| duty_sel | input | 2 | Duty select (row count 3/4/5) |
| blank_en | input | 1 | Forces all segments to the off pattern |
| row_bits | input | 300 | Five 60-bit row words; row r occupies bits [r*60+59:r*60] |
| com_lvl | output | 10 | Level code per common, 2 bits each |
| seg_lvl | output | 120 | Level code per segment, 2 bits each |

## Verification
A vector table runs a complete scan of two frames for each duty encoding. This includes both encodings that give five rows, so a decoder that reads the don't-care bit is exposed. The table also covers blank both on and off. Row words come from a seed-dependent pattern that differs per row, so a wrong row mux or an off-by-one slot shows up as a segment mismatch. Directed tests then probe the exact tick count at a half-phase boundary, long idle stretches without ticks, and a mid-frame duty change. They also check that toggling the low select bit in five-row mode does not restart the scan, and that blank can be toggled mid-slot.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int MAX_ROWS = 5;
  localparam int SLOT_W   = $clog2(MAX_ROWS + 1);

  // Drive level codes, ordered by voltage
  typedef enum logic [1:0] {
    LVL_L  = 2'b00,
    LVL_M2 = 2'b01,
    LVL_M1 = 2'b10,
    LVL_H  = 2'b11
  } drv_lvl_e;

  // Number of scanned rows for a duty select value
  function automatic logic [SLOT_W-1:0] rows_for_duty(input logic [1:0] sel);
    if (sel[1])      return SLOT_W'(5);
    else if (sel[0]) return SLOT_W'(4);
    else             return SLOT_W'(3);
  endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase
  import lcdseq_pkg::*;
#(
  parameter int HALF_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic [1:0]        duty_sel,
  output logic [SLOT_W-1:0] slot,
  output logic              phase,
  output logic [SLOT_W-1:0] rows
);

  localparam int TICK_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(HALF_TICKS - 1);

  logic [TICK_W-1:0] tick_q;
  logic              phase_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] rows_q;
  logic [SLOT_W-1:0] rows_dec;
  logic              restart;
  logic              half_end;
  logic              slot_last;

  assign rows_dec  = rows_for_duty(duty_sel);
  assign restart   = (rows_dec != rows_q);
  assign half_end  = osc_tick && (tick_q == TICK_LAST);
  assign slot_last = (slot_q == rows_q - SLOT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q  <= '0;
      phase_q <= 1'b0;
      slot_q  <= '0;
      rows_q  <= SLOT_W'(MAX_ROWS);
    end else if (restart) begin
      tick_q  <= '0;
      phase_q <= 1'b0;
      slot_q  <= '0;
      rows_q  <= rows_dec;
    end else if (osc_tick) begin
      if (half_end) begin
        tick_q  <= '0;
        phase_q <= ~phase_q;
        if (phase_q) begin
          slot_q <= slot_last ? '0 : slot_q + SLOT_W'(1);
        end
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end

  assign slot  = slot_q;
  assign phase = phase_q;
  assign rows  = rows_q;

endmodule

// File: rtl/lcdseq_com_gen.sv
module lcdseq_com_gen
  import lcdseq_pkg::*;
#(
  parameter int NUM_COM = MAX_ROWS
) (
  input  logic [SLOT_W-1:0]    slot,
  input  logic                 phase,
  input  logic [SLOT_W-1:0]    rows,
  output logic [2*NUM_COM-1:0] com_lvl
);

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic     active;
    logic     selected;
    drv_lvl_e lvl;

    assign active   = (SLOT_W'(c) < rows);
    assign selected = active && (slot == SLOT_W'(c));

    always_comb begin
      if (selected) lvl = phase ? LVL_L  : LVL_H;
      else          lvl = phase ? LVL_M1 : LVL_M2;
    end

    assign com_lvl[2*c +: 2] = lvl;
  end

endmodule

// File: rtl/lcdseq_seg_gen.sv
module lcdseq_seg_gen
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int NUM_COM = MAX_ROWS
) (
  input  logic [SLOT_W-1:0]          slot,
  input  logic                       phase,
  input  logic                       blank_en,
  input  logic [NUM_COM*NUM_SEG-1:0] row_bits,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);

  logic [NUM_SEG-1:0] cur_word;

  // One shared row mux feeds all segment encoders
  always_comb begin
    cur_word = '0;
    for (int r = 0; r < NUM_COM; r++) begin
      if (slot == SLOT_W'(r)) cur_word = row_bits[r*NUM_SEG +: NUM_SEG];
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic     lit;
    drv_lvl_e lvl;

    assign lit = cur_word[s] & ~blank_en;

    always_comb begin
      if (lit) lvl = phase ? LVL_H  : LVL_L;
      else     lvl = phase ? LVL_M2 : LVL_M1;
    end

    assign seg_lvl[2*s +: 2] = lvl;
  end

endmodule

// File: rtl/lcdmux_drive_seq.sv
module lcdmux_drive_seq
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG    = 60,
  parameter int NUM_COM    = MAX_ROWS,
  parameter int HALF_TICKS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_tick,
  input  logic [1:0]                 duty_sel,
  input  logic                       blank_en,
  input  logic [NUM_COM*NUM_SEG-1:0] row_bits,
  output logic [2*NUM_COM-1:0]       com_lvl,
  output logic [2*NUM_SEG-1:0]       seg_lvl
);

  logic [SLOT_W-1:0] slot;
  logic              phase;
  logic [SLOT_W-1:0] rows;

  lcdseq_timebase #(
    .HALF_TICKS(HALF_TICKS)
  ) u_timebase (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .duty_sel (duty_sel),
    .slot     (slot),
    .phase    (phase),
    .rows     (rows)
  );

  lcdseq_com_gen #(
    .NUM_COM(NUM_COM)
  ) u_com (
    .slot    (slot),
    .phase   (phase),
    .rows    (rows),
    .com_lvl (com_lvl)
  );

  lcdseq_seg_gen #(
    .NUM_SEG(NUM_SEG),
    .NUM_COM(NUM_COM)
  ) u_seg (
    .slot     (slot),
    .phase    (phase),
    .blank_en (blank_en),
    .row_bits (row_bits),
    .seg_lvl  (seg_lvl)
  );

endmodule

// File: rtl/lcdseq_checker.sv
module lcdseq_checker
  import lcdseq_pkg::*;
#(
  parameter int NUM_SEG = 60,
  parameter int NUM_COM = MAX_ROWS
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_tick,
  input logic [1:0]           duty_sel,
  input logic                 blank_en,
  input logic [2*NUM_COM-1:0] com_lvl,
  input logic [2*NUM_SEG-1:0] seg_lvl
);

  logic [NUM_COM-1:0] com_sel;   // common at H or L
  logic [NUM_COM-1:0] com_lsb;
  logic [NUM_SEG-1:0] seg_lsb;
  logic [NUM_SEG-1:0] seg_mid;   // segment at M1 or M2

  always_comb begin
    for (int c = 0; c < NUM_COM; c++) begin
      com_sel[c] = (com_lvl[2*c+1] == com_lvl[2*c]);
      com_lsb[c] = com_lvl[2*c];
    end
    for (int s = 0; s < NUM_SEG; s++) begin
      seg_lsb[s] = seg_lvl[2*s];
      seg_mid[s] = (seg_lvl[2*s+1] != seg_lvl[2*s]);
    end
  end

  // R5: exactly one common is selected at any time
  p_one_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1);

  // R6/R7/R8: commons share one half-phase, segments run in the opposite one
  p_phase_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&com_lsb) || !(|com_lsb)) && (seg_lsb == {NUM_SEG{~com_lsb[0]}}));

  // R9: blank keeps all segments on the mid levels
  p_blank_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_en |-> (&seg_mid));

  // R3: no tick and no duty change means no output change
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && $stable(duty_sel)) |=> $stable(com_lvl));

  // R1: after reset, common 0 is first and in its first half-phase
  p_reset_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (com_lvl[1:0] == 2'b11));

  // R10: a decoded row count change restarts at slot 0, first half
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rows_for_duty(duty_sel) != rows_for_duty($past(duty_sel)))
      |=> (com_lvl[1:0] == 2'b11));

endmodule

bind lcdmux_drive_seq lcdseq_checker #(
  .NUM_SEG(NUM_SEG),
  .NUM_COM(NUM_COM)
) u_lcdseq_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .osc_tick (osc_tick),
  .duty_sel (duty_sel),
  .blank_en (blank_en),
  .com_lvl  (com_lvl),
  .seg_lvl  (seg_lvl)
);

// File: tb/test_lcdmux_drive_seq.sv
module test_lcdmux_drive_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 60;
  localparam int NCOM = 5;
  localparam int HALF = 8;
  localparam int NVEC = 6;

  // Vector: [15:14] duty_sel, [13] blank, [12:10] expected rows, [7:0] seed
  localparam logic [15:0] VECS [NVEC] = '{
    {2'b00, 1'b0, 3'd3, 2'b00, 8'd11},
    {2'b01, 1'b0, 3'd4, 2'b00, 8'd23},
    {2'b10, 1'b0, 3'd5, 2'b00, 8'd37},
    {2'b11, 1'b0, 3'd5, 2'b00, 8'd41},
    {2'b10, 1'b1, 3'd5, 2'b00, 8'd53},
    {2'b00, 1'b1, 3'd3, 2'b00, 8'd67}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 osc_tick = 1'b0;
  logic [1:0]           duty_sel = 2'b10;
  logic                 blank_en = 1'b0;
  logic [NCOM*NSEG-1:0] row_bits = '0;
  logic [2*NCOM-1:0]    com_lvl;
  logic [2*NSEG-1:0]    seg_lvl;

  int n_checks = 0;
  int n_fail   = 0;
  int m_slot, m_phase, m_rows;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdmux_drive_seq i_lcdmux_drive_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .duty_sel (duty_sel),
    .blank_en (blank_en),
    .row_bits (row_bits),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

  function automatic logic [NCOM*NSEG-1:0] make_rows(input int seed);
    logic [NCOM*NSEG-1:0] w;
    for (int r = 0; r < NCOM; r++)
      for (int s = 0; s < NSEG; s++)
        w[r*NSEG+s] = (((s*3 + r*5 + seed) % 7) < 3);
    return w;
  endfunction

  // Expected commons: R5, R6 (H=11, M1=10, M2=01, L=00)
  function automatic logic [2*NCOM-1:0] exp_com(input int sl, input int ph, input int nr);
    logic [2*NCOM-1:0] v;
    for (int c = 0; c < NCOM; c++) begin
      if (c < nr && c == sl) v[2*c +: 2] = ph ? 2'b00 : 2'b11;
      else                   v[2*c +: 2] = ph ? 2'b10 : 2'b01;
    end
    return v;
  endfunction

  // Expected segments: R7, R8, R9
  function automatic logic [2*NSEG-1:0] exp_seg(input int sl, input int ph);
    logic [2*NSEG-1:0] v;
    for (int s = 0; s < NSEG; s++) begin
      if (row_bits[sl*NSEG+s] && !blank_en) v[2*s +: 2] = ph ? 2'b11 : 2'b00;
      else                                   v[2*s +: 2] = ph ? 2'b01 : 2'b10;
    end
    return v;
  endfunction

  task automatic check_state(input string tc, input string ts);
    logic [2*NCOM-1:0] ec;
    logic [2*NSEG-1:0] es;
    ec = exp_com(m_slot, m_phase, m_rows);
    es = exp_seg(m_slot, m_phase);
    n_checks++;
    if (com_lvl !== ec) begin
      n_fail++;
      $display("FAIL %s com: actual %h expected %h (slot %0d phase %0d)", tc, com_lvl, ec, m_slot, m_phase);
    end
    n_checks++;
    if (seg_lvl !== es) begin
      n_fail++;
      $display("FAIL %s seg: actual %h expected %h (slot %0d phase %0d)", ts, seg_lvl, es, m_slot, m_phase);
    end
  endtask

  task automatic tick();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
  endtask

  task automatic advance_half();
    repeat (HALF) tick();
    m_phase ^= 1;
    if (m_phase == 0) m_slot = (m_slot + 1) % m_rows;
  endtask

  task automatic do_reset(input int nr);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_slot = 0; m_phase = 0; m_rows = nr;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    // Table walk: R1, R2, R4, R5, R6, R7, R8, R9
    for (int v = 0; v < NVEC; v++) begin
      duty_sel = VECS[v][15:14];
      blank_en = VECS[v][13];
      row_bits = make_rows(int'(VECS[v][7:0]));
      do_reset(int'(VECS[v][12:10]));
      check_state("R1 reset", "R1 reset");
      for (int k = 0; k < 4*m_rows; k++) begin
        advance_half();
        check_state("R2/R4/R5/R6", VECS[v][13] ? "R9 blank" : "R7/R8");
      end
    end

    // R3: exact tick count and idle stability
    duty_sel = 2'b01; blank_en = 1'b0; row_bits = make_rows(5);
    do_reset(4);
    repeat (HALF-1) tick();
    check_state("R3 seven ticks", "R3 seven ticks");
    repeat (25) @(negedge clk);
    check_state("R3 idle", "R3 idle");
    tick();
    m_phase = 1;
    check_state("R3 eighth tick", "R3 eighth tick");

    // R10: mid-frame duty change restarts the scan
    duty_sel = 2'b10;
    do_reset(5);
    repeat (7) advance_half();
    check_state("R4 slot3", "R7 slot3");
    @(negedge clk) duty_sel = 2'b00;
    @(negedge clk);
    m_slot = 0; m_phase = 0; m_rows = 3;
    check_state("R10 restart", "R10 restart");
    repeat (3) advance_half();
    check_state("R10 after restart", "R10 after restart");

    // R10: low select bit toggles in five-row mode without restart
    @(negedge clk) duty_sel = 2'b10;
    @(negedge clk);
    m_slot = 0; m_phase = 0; m_rows = 5;
    repeat (5) advance_half();
    check_state("R10 pre toggle", "R10 pre toggle");
    @(negedge clk) duty_sel = 2'b11;
    repeat (3) @(negedge clk);
    check_state("R10 no restart", "R10 no restart");
    repeat (4) advance_half();
    check_state("R4 slot4 used", "R8 slot4");

    // R9: blank toggled mid-slot; commons keep scanning
    @(negedge clk) blank_en = 1'b1;
    @(negedge clk);
    check_state("R9 com scan", "R9 blank on");
    advance_half();
    check_state("R9 com scan", "R9 blank on");
    @(negedge clk) blank_en = 1'b0;
    @(negedge clk);
    check_state("R9 com scan", "R9 blank off");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule